// File: doc/BRIEF.md
# Random Memory Stress Tester

This block generates pseudo-random single-byte memory traffic on one requester port and checks what comes back. A 32-bit LFSR supplies, each cycle, a command draw, an uncacheable draw, a region bit, an offset and a data byte. The offset is aligned down to a block boundary and the tester's own lane number is added. Several testers with different lane numbers therefore contend for the same blocks without ever touching the same byte.

A local shadow memory holds the byte each address should contain. The shadow has one entry per reachable address of this tester's lane in each of the three regions. A read captures its expected byte when the port accepts it. A write reaches the shadow only when its response comes back without error.

A small slot table tracks the requests in flight. The slot index travels with the request as its tag, and the response returns that tag. A request whose address is already in flight is dropped for that cycle. A request the port refuses is held unchanged until the port takes it. A watchdog raises a deadlock flag when responses stop arriving. A done flag marks the point where a configured number of reads has completed.

Top module: `mem_stress_tester`

## Requirements
- R1: A request is a read when its command draw (always in 0..99) is below `cfg_read_pct`, and a write otherwise. With `cfg_read_pct` = 0 every request is a write; with 100 every request is a read.
- R2: The address offset is a block-aligned value below `MEM_BYTES` plus the lane `ID`. Every request address therefore has its low log2(`BLK_BYTES`) bits equal to `ID`, and its offset (`addr` mod `MEM_BYTES`) is below `MEM_BYTES`.
- R3: An uncacheable request, chosen when its draw in 0..99 is below `cfg_unc_pct`, uses base 0x800000 and raises `req_uncached`. Any other request uses base 0x100000 or 0x400000 with `req_uncached` low. `cfg_unc_pct` = 0 gives no uncacheable requests and 100 gives only uncacheable ones.
- R4: No two accepted, uncompleted requests share an address or a tag. At most `SLOTS` requests are in flight, and issue stalls while all slots are busy.
- R5: While `req_valid` is high and `req_ready` is low, the next cycle keeps `req_valid` high with address, write flag, uncacheable flag, data and tag unchanged.
- R6: A non-error read response whose byte differs from the expected byte sets `mismatch`. `mismatch` stays set until reset. Correct read data never sets it.
- R7: A non-error write response stores the written byte in the shadow memory, and later reads of that address expect it. An error response frees its slot but updates neither the shadow nor any counter, and it is never checked for data.
- R8: `rd_count` and `wr_count` count the non-error read and write responses.
- R9: `deadlock` rises after `STALL_LIMIT` consecutive clock edges with no response, and drops in the cycle after any response.
- R10: `done` is high exactly when `cfg_max_loads` is nonzero and `rd_count` >= `cfg_max_loads`.
- R11: After synchronous reset, `mismatch`, `deadlock` and `done` are low, both counters are zero and every shadow byte is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_read_pct | input | 7 | Read percentage, 0..100 |
| cfg_unc_pct | input | 7 | Uncacheable percentage, 0..100 |
| cfg_max_loads | input | 32 | Read count that raises done; 0 disables |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Port accepts the request |
| req_addr | output | 24 | Byte address |
| req_write | output | 1 | 1 = write, 0 = read |
| req_uncached | output | 1 | Uncacheable access |
| req_wdata | output | 8 | Write byte |
| req_tag | output | log2(SLOTS) | Slot tag of the request |
| rsp_valid | input | 1 | Response present |
| rsp_tag | input | log2(SLOTS) | Tag of the completed request |
| rsp_data | input | 8 | Read byte |
| rsp_err | input | 1 | Access failed |
| mismatch | output | 1 | Sticky read data mismatch |
| deadlock | output | 1 | No response for STALL_LIMIT cycles |
| done | output | 1 | Read target reached |
| rd_count | output | 32 | Completed reads |
| wr_count | output | 32 | Completed writes |

## Verification
Traffic runs under a series of configurations. A write-only phase fills the shadow and a read-only phase then checks it, so the two extremes of the read percentage can be told apart from mixed traffic. Uncacheable percentages of 0, 40 and 100 separate the three bases. Acceptance that refuses every third request exercises the hold path. Response latencies from 2 to 30 cycles go from an almost empty slot table to a full one, and every fourth response of some phases is an error carrying wrong data, so any shadow update or data check on an error turns up as a later read mismatch. Directed steps then corrupt one good read byte, count reads up to a load target, and starve the port until the watchdog fires and a single response clears it.

// File: rtl/mst_pkg.sv
// Package: shared constants, region encoding and the mod-100 reduction
// used by the random memory stress tester.
package mst_pkg;

    localparam int ADDR_W = 24;

    localparam logic [ADDR_W-1:0] BASE_LOW  = 24'h400000;
    localparam logic [ADDR_W-1:0] BASE_HIGH = 24'h100000;
    localparam logic [ADDR_W-1:0] BASE_UNC  = 24'h800000;

    typedef enum logic [1:0] {
        RGN_LOW  = 2'd0,
        RGN_HIGH = 2'd1,
        RGN_UNC  = 2'd2
    } region_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              uncached;
        logic [7:0]        wdata;
    } req_s;

    // Folds a 7-bit draw (0..127) into 0..99 with one compare and subtract.
    function automatic logic [6:0] fold100(input logic [6:0] v);
        return (v >= 7'd100) ? v - 7'd100 : v;
    endfunction

endpackage

// File: rtl/mst_lfsr.sv
// Module: mst_lfsr
// 32-bit maximal-length Galois LFSR (x^32+x^22+x^2+x+1).
// Assumes SEED is nonzero; advances only when step is high.
module mst_lfsr #(
    parameter logic [31:0] SEED = 32'h1ACE_B00C
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    output logic [31:0] state
);
    localparam logic [31:0] POLY = 32'h0040_0007;

    // Shift register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SEED;
        else if (step)
            state <= {state[30:0], 1'b0} ^ (state[31] ? POLY : 32'h0);
    end
endmodule

// File: rtl/mst_shadow.sv
// Module: mst_shadow
// Expected-content store, one byte per reachable address of this lane.
// Combinational read, synchronous write; cleared to zero by reset.
module mst_shadow #(
    parameter int IDX_W = 6,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data
);
    logic [7:0] mem [DEPTH];

    // Storage update and reset clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Read port.
    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/mst_slots.sv
// Module: mst_slots
// Outstanding-request table. Each slot holds the shadow index, the
// direction and a byte (expected read byte or written byte). Offers the
// lowest free slot, an address-in-flight probe and a lookup by tag.
// Assumes alloc and free never name the same slot in one cycle.
module mst_slots #(
    parameter int SLOTS = 8,
    parameter int IDX_W = 6,
    localparam int TAG_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic             alloc_rd,
    input  logic [7:0]       alloc_byte,
    input  logic             free_en,
    input  logic [TAG_W-1:0] free_tag,
    input  logic [IDX_W-1:0] probe_idx,
    output logic             probe_hit,
    output logic             full,
    output logic [TAG_W-1:0] next_tag,
    output logic             look_rd,
    output logic [7:0]       look_byte,
    output logic [IDX_W-1:0] look_idx
);
    logic [SLOTS-1:0] busy;
    logic [IDX_W-1:0] s_idx  [SLOTS];
    logic             s_rd   [SLOTS];
    logic [7:0]       s_byte [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Per-slot occupancy and contents.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy[g]   <= 1'b0;
                s_idx[g]  <= '0;
                s_rd[g]   <= 1'b0;
                s_byte[g] <= 8'h00;
            end else if (alloc_en && alloc_tag == TAG_W'(g)) begin
                busy[g]   <= 1'b1;
                s_idx[g]  <= alloc_idx;
                s_rd[g]   <= alloc_rd;
                s_byte[g] <= alloc_byte;
            end else if (free_en && free_tag == TAG_W'(g)) begin
                busy[g]   <= 1'b0;
            end
        end
    end

    // Lowest free slot, fullness and duplicate-address probe.
    always_comb begin
        next_tag  = '0;
        probe_hit = 1'b0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!busy[i]) next_tag = TAG_W'(i);
            if (busy[i] && s_idx[i] == probe_idx) probe_hit = 1'b1;
        end
        full = &busy;
    end

    // Lookup of the responding slot.
    assign look_rd   = s_rd[free_tag];
    assign look_byte = s_byte[free_tag];
    assign look_idx  = s_idx[free_tag];
endmodule

// File: rtl/mem_stress_tester.sv
// Module: mem_stress_tester
// Pseudo-random single-byte traffic generator and checker for one
// requester port. Draws operation, region and block from an LFSR, places
// the access on lane ID of the block, blocks addresses already in flight,
// holds refused requests, checks read data against a shadow memory that is
// updated on write completion, and watches for stalled responses.
// Assumes: MEM_BYTES and BLK_BYTES powers of two, ID < BLK_BYTES,
// log2(MEM_BYTES) <= 9, SLOTS a power of two, responses carry live tags.
module mem_stress_tester #(
    parameter int          ID          = 3,
    parameter int          BLK_BYTES   = 16,
    parameter int          MEM_BYTES   = 256,
    parameter int          SLOTS       = 8,
    parameter int          STALL_LIMIT = 500000,
    parameter logic [31:0] SEED        = 32'h1ACE_B00C,
    localparam int         TAG_W       = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [6:0]       cfg_read_pct,
    input  logic [6:0]       cfg_unc_pct,
    input  logic [31:0]      cfg_max_loads,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [23:0]      req_addr,
    output logic             req_write,
    output logic             req_uncached,
    output logic [7:0]       req_wdata,
    output logic [TAG_W-1:0] req_tag,
    input  logic             rsp_valid,
    input  logic [TAG_W-1:0] rsp_tag,
    input  logic [7:0]       rsp_data,
    input  logic             rsp_err,
    output logic             mismatch,
    output logic             deadlock,
    output logic             done,
    output logic [31:0]      rd_count,
    output logic [31:0]      wr_count
);
    import mst_pkg::*;

    localparam int BLK_W  = $clog2(BLK_BYTES);
    localparam int OFF_W  = $clog2(MEM_BYTES);
    localparam int NBLK_W = OFF_W - BLK_W;
    localparam int IDX_W  = NBLK_W + 2;
    localparam int CNT_W  = $clog2(STALL_LIMIT + 1);
    localparam logic [BLK_W-1:0] LANE  = BLK_W'(ID);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STALL_LIMIT);

    logic [31:0]       rnd;
    logic              hold_q;
    req_s              held_q, cand, cur;
    logic [IDX_W-1:0]  held_idx_q, cand_idx, cur_idx;
    logic [TAG_W-1:0]  held_tag_q, next_tag;
    logic              probe_hit, full, launch, accept;
    logic              look_rd;
    logic [7:0]        look_byte, shadow_byte;
    logic [IDX_W-1:0]  look_idx;
    logic [CNT_W-1:0]  idle_q;
    region_e           rgn;
    logic [NBLK_W-1:0] blk;
    logic              good_rsp;

    mst_lfsr #(.SEED(SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .step(!hold_q), .state(rnd)
    );

    // Candidate request formed from the current random word.
    always_comb begin
        logic unc;
        logic [ADDR_W-1:0] base;
        unc = fold100(rnd[13:7]) < cfg_unc_pct;
        blk = rnd[15+BLK_W +: NBLK_W];
        rgn = unc ? RGN_UNC : (rnd[14] ? RGN_HIGH : RGN_LOW);
        case (rgn)
            RGN_UNC:  base = BASE_UNC;
            RGN_HIGH: base = BASE_HIGH;
            default:  base = BASE_LOW;
        endcase
        cand.addr     = base + ADDR_W'({blk, LANE});
        cand.write    = !(fold100(rnd[6:0]) < cfg_read_pct);
        cand.uncached = unc;
        cand.wdata    = rnd[31:24];
        cand_idx      = {rgn, blk};
    end

    mst_slots #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(accept), .alloc_tag(req_tag), .alloc_idx(cur_idx),
        .alloc_rd(!req_write),
        .alloc_byte(req_write ? req_wdata : shadow_byte),
        .free_en(rsp_valid), .free_tag(rsp_tag),
        .probe_idx(cand_idx), .probe_hit(probe_hit), .full(full),
        .next_tag(next_tag),
        .look_rd(look_rd), .look_byte(look_byte), .look_idx(look_idx)
    );

    assign good_rsp = rsp_valid && !rsp_err;

    mst_shadow #(.IDX_W(IDX_W)) u_shadow (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(cur_idx), .rd_data(shadow_byte),
        .wr_en(good_rsp && !look_rd), .wr_idx(look_idx), .wr_data(look_byte)
    );

    // Issue selection: held request first, else a fresh non-duplicate one.
    always_comb begin
        launch       = !hold_q && !full && !probe_hit;
        req_valid    = hold_q || launch;
        cur          = hold_q ? held_q : cand;
        cur_idx      = hold_q ? held_idx_q : cand_idx;
        req_tag      = hold_q ? held_tag_q : next_tag;
        req_addr     = cur.addr;
        req_write    = cur.write;
        req_uncached = cur.uncached;
        req_wdata    = cur.wdata;
        accept       = req_valid && req_ready;
    end

    // Hold register for a refused request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q     <= 1'b0;
            held_q     <= '0;
            held_idx_q <= '0;
            held_tag_q <= '0;
        end else if (launch && !req_ready) begin
            hold_q     <= 1'b1;
            held_q     <= cand;
            held_idx_q <= cand_idx;
            held_tag_q <= next_tag;
        end else if (hold_q && req_ready) begin
            hold_q     <= 1'b0;
        end
    end

    // Response checking and completion counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mismatch <= 1'b0;
            rd_count <= '0;
            wr_count <= '0;
        end else if (good_rsp) begin
            if (look_rd) begin
                rd_count <= rd_count + 32'd1;
                if (rsp_data != look_byte) mismatch <= 1'b1;
            end else begin
                wr_count <= wr_count + 32'd1;
            end
        end
    end

    // Stall watchdog: cycles since the last response, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || rsp_valid)
            idle_q <= '0;
        else if (idle_q != LIMIT)
            idle_q <= idle_q + CNT_W'(1);
    end

    assign deadlock = (idle_q == LIMIT);
    assign done     = (cfg_max_loads != 32'd0) && (rd_count >= cfg_max_loads);
endmodule

// File: rtl/mst_checker.sv
// Module: mst_checker
// Port-level properties of the stress tester, bound to every instance.
module mst_checker #(
    parameter int ID        = 3,
    parameter int BLK_BYTES = 16,
    parameter int MEM_BYTES = 256,
    parameter int TAG_W     = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [23:0]      req_addr,
    input logic             req_write,
    input logic             req_uncached,
    input logic [7:0]       req_wdata,
    input logic [TAG_W-1:0] req_tag,
    input logic             rsp_valid,
    input logic             mismatch,
    input logic             deadlock,
    input logic [31:0]      rd_count,
    input logic [31:0]      wr_count
);
    localparam logic [23:0] OFF_MASK  = 24'(MEM_BYTES - 1);
    localparam logic [23:0] LANE_MASK = 24'(BLK_BYTES - 1);

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
        $stable(req_write) && $stable(req_uncached) &&
        $stable(req_wdata) && $stable(req_tag));

    assert_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr & LANE_MASK) == 24'(ID));

    assert_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_uncached == ((req_addr & ~OFF_MASK) == 24'h800000));

    assert_mismatch_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> mismatch);

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_count == $past(rd_count) || rd_count == $past(rd_count) + 32'd1) &&
        (wr_count == $past(wr_count) || wr_count == $past(wr_count) + 32'd1));

    assert_deadlock_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !deadlock);
endmodule

bind mem_stress_tester mst_checker #(
    .ID(ID), .BLK_BYTES(BLK_BYTES), .MEM_BYTES(MEM_BYTES), .TAG_W(TAG_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_uncached(req_uncached),
    .req_wdata(req_wdata), .req_tag(req_tag), .rsp_valid(rsp_valid),
    .mismatch(mismatch), .deadlock(deadlock),
    .rd_count(rd_count), .wr_count(wr_count)
);

// File: tb/sim_mem_stress_tester.sv
// Bench: models the memory behind the port, checks each request against
// the requirements and walks a table of traffic configurations, then runs
// directed tests for mismatch, load target and the stall watchdog.
module sim_mem_stress_tester;
    localparam int ID = 3, BLK = 16, MEM = 256, SLOTS = 8, LIMIT = 300;
    localparam int WD = 150000;
    localparam int NV = 6;
    // {read_pct, unc_pct, ready_mode, err_mode, latency}
    localparam logic [31:0] VEC [NV] = '{
        {8'd0,   8'd0,   4'd0, 4'd0, 8'd2},
        {8'd100, 8'd0,   4'd0, 4'd0, 8'd3},
        {8'd50,  8'd100, 4'd1, 4'd0, 8'd4},
        {8'd60,  8'd40,  4'd1, 4'd1, 8'd5},
        {8'd100, 8'd40,  4'd1, 4'd0, 8'd30},
        {8'd30,  8'd0,   4'd1, 4'd1, 8'd12}
    };

    logic clk = 0, rst_n = 0;
    logic [6:0] cfg_read_pct = 0, cfg_unc_pct = 0;
    logic [31:0] cfg_max_loads = 0;
    logic req_valid, req_ready = 0, req_write, req_uncached;
    logic [23:0] req_addr;
    logic [7:0] req_wdata, rsp_data = 0;
    logic [2:0] req_tag, rsp_tag = 0;
    logic rsp_valid = 0, rsp_err = 0;
    logic mismatch, deadlock, done;
    logic [31:0] rd_count, wr_count;

    always #2 clk = ~clk;

    mem_stress_tester #(.ID(ID), .BLK_BYTES(BLK), .MEM_BYTES(MEM),
        .SLOTS(SLOTS), .STALL_LIMIT(LIMIT)) u0 (.*);

    int checks = 0, errors = 0, cyc = 0;
    logic [7:0] model [64];
    bit busy_tag [8];
    bit busy_idx [64];
    int q_tag [32], q_idx [32], q_due [32];
    bit q_rd [32];
    logic [7:0] q_wd [32];
    int q_head = 0, q_tail = 0, rsp_seq = 0, last_rsp = 0;
    int ready_mode = 2, err_mode = 0, lat = 2;
    bit rsp_en = 1, corrupt_next = 0, skip_first = 0;
    int n_acc, n_rd, n_wr, n_unc, n_out, max_out = 0;
    int bench_rd = 0, bench_wr = 0;
    bit prev_ref = 0;
    logic [23:0] p_addr; logic p_wr, p_unc; logic [7:0] p_wd; logic [2:0] p_tag;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic accept_req();
        int off, rgn, idx;
        logic [23:0] base;
        off  = int'(req_addr) % MEM;
        base = req_addr - 24'(off);
        rgn  = (base == 24'h400000) ? 0 : (base == 24'h100000) ? 1 :
               (base == 24'h800000) ? 2 : -1;
        chk(off % BLK == ID, "R2 lane", 32'(off % BLK), 32'(ID));
        chk(rgn >= 0, "R3 base", 32'(base), 32'h800000);
        chk(req_uncached == (rgn == 2), "R3 uncached flag", 32'(req_uncached), 32'(rgn == 2));
        if (rgn < 0) rgn = 0;
        idx = rgn * (MEM / BLK) + off / BLK;
        chk(!busy_tag[req_tag], "R4 tag in use", 32'(req_tag), 32'hffff);
        chk(!busy_idx[idx], "R4 address in flight", 32'(req_addr), 32'hffff);
        busy_tag[req_tag] = 1; busy_idx[idx] = 1;
        q_tag[q_tail] = int'(req_tag); q_idx[q_tail] = idx;
        q_rd[q_tail] = !req_write; q_wd[q_tail] = req_wdata;
        q_due[q_tail] = cyc + lat; q_tail = (q_tail + 1) % 32;
        if (skip_first) skip_first = 0;
        else begin
            n_acc++;
            if (req_write) n_wr++; else n_rd++;
            if (req_uncached) n_unc++;
        end
    endtask

    task automatic send_rsp();
        bit err;
        int h;
        h = q_head;
        err = (err_mode != 0) && (rsp_seq % 4 == 3);
        rsp_seq++;
        rsp_valid = 1; rsp_tag = 3'(q_tag[h]); rsp_err = err;
        rsp_data = q_rd[h] ? model[q_idx[h]] : 8'h00;
        if (err) rsp_data = ~model[q_idx[h]];
        else if (q_rd[h]) begin
            bench_rd++;
            if (corrupt_next) begin rsp_data = rsp_data ^ 8'h5A; corrupt_next = 0; end
        end else begin
            model[q_idx[h]] = q_wd[h];
            bench_wr++;
        end
        busy_tag[q_tag[h]] = 0; busy_idx[q_idx[h]] = 0;
        last_rsp = cyc;
        q_head = (q_head + 1) % 32;
    endtask

    task automatic step();
        bit rdy;
        @(negedge clk);
        cyc++;
        if (cyc >= WD) begin
            errors++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, WD);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        if (prev_ref)
            chk(req_valid && req_addr == p_addr && req_write == p_wr &&
                req_uncached == p_unc && req_wdata == p_wd && req_tag == p_tag,
                "R5 held request changed", 32'(req_addr), 32'(p_addr));
        rdy = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? (cyc % 3 != 0) : 1'b0;
        req_ready = rdy;
        if (req_valid && rdy) accept_req();
        prev_ref = req_valid && !rdy;
        p_addr = req_addr; p_wr = req_write; p_unc = req_uncached;
        p_wd = req_wdata; p_tag = req_tag;
        n_out = 0;
        for (int i = 0; i < 8; i++) n_out += int'(busy_tag[i]);
        if (n_out > max_out) max_out = n_out;
        rsp_valid = 0; rsp_err = 0;
        if (rsp_en && q_head != q_tail && q_due[q_head] <= cyc) send_rsp();
    endtask

    task automatic drain();
        ready_mode = 2;
        while (q_head != q_tail) step();
        repeat (3) step();
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin model[i] = 0; busy_idx[i] = 0; end
        for (int i = 0; i < 8; i++) busy_tag[i] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        chk(!mismatch && !deadlock && !done, "R11 flags after reset",
            {mismatch, deadlock, done}, 0);
        chk(rd_count == 0 && wr_count == 0, "R11 counters after reset", rd_count | wr_count, 0);

        for (int v = 0; v < NV; v++) begin
            int rp, up;
            rp = int'(VEC[v][31:24]); up = int'(VEC[v][23:16]);
            cfg_read_pct = 7'(rp); cfg_unc_pct = 7'(up);
            err_mode = int'(VEC[v][11:8]); lat = int'(VEC[v][7:0]);
            n_acc = 0; n_rd = 0; n_wr = 0; n_unc = 0; skip_first = prev_ref;
            ready_mode = int'(VEC[v][15:12]);
            repeat (600) step();
            drain();
            chk(n_acc > 20, "R1 traffic issued", 32'(n_acc), 21);
            if (rp == 0) chk(n_rd == 0, "R1 no reads at 0", 32'(n_rd), 0);
            else if (rp == 100) chk(n_wr == 0, "R1 no writes at 100", 32'(n_wr), 0);
            else chk(n_rd > 0 && n_wr > 0, "R1 mixed traffic", 32'(n_rd), 32'(n_wr));
            if (up == 0) chk(n_unc == 0, "R3 none uncacheable", 32'(n_unc), 0);
            else if (up == 100) chk(n_unc == n_acc, "R3 all uncacheable", 32'(n_unc), 32'(n_acc));
            else chk(n_unc > 0 && n_unc < n_acc, "R3 mixed regions", 32'(n_unc), 32'(n_acc));
            chk(!mismatch, "R6 R7 no false mismatch", 32'(mismatch), 0);
            chk(rd_count == 32'(bench_rd), "R8 read count", rd_count, 32'(bench_rd));
            chk(wr_count == 32'(bench_wr), "R8 write count", wr_count, 32'(bench_wr));
            if (lat == 30) chk(max_out == SLOTS, "R4 table fills to SLOTS", 32'(max_out), SLOTS);
        end

        // R10: load target
        begin
            int target;
            target = bench_rd + 25;
            cfg_max_loads = 32'(target);
            cfg_read_pct = 100; cfg_unc_pct = 0; err_mode = 0; lat = 2;
            skip_first = prev_ref; ready_mode = 0;
            while (bench_rd < target + 5) begin
                int seen;
                seen = bench_rd;
                step();
                chk(done == (seen >= target), "R10 done flag", 32'(done), 32'(seen >= target));
            end
            drain();
        end

        // R6: one corrupted read byte
        cfg_max_loads = 0;
        chk(!mismatch, "R6 clean before corruption", 32'(mismatch), 0);
        corrupt_next = 1; ready_mode = 0;
        while (corrupt_next) step();
        step();
        chk(mismatch, "R6 mismatch on wrong byte", 32'(mismatch), 1);
        drain();

        // R9: stall watchdog with one response withheld
        rsp_en = 0; ready_mode = 0;
        while (q_head == q_tail) step();
        ready_mode = 2;
        while (cyc - last_rsp < LIMIT - 5) step();
        chk(!deadlock, "R9 no deadlock before limit", 32'(deadlock), 0);
        while (cyc - last_rsp < LIMIT + 5) step();
        chk(deadlock, "R9 deadlock after limit", 32'(deadlock), 1);
        rsp_en = 1;
        step();
        step();
        chk(!deadlock, "R9 response clears deadlock", 32'(deadlock), 0);
        chk(mismatch, "R6 mismatch sticky", 32'(mismatch), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule